// File: doc/BRIEF.md
# Shared-Memory Virtual Output Queue Packet Store

This block is the packet store on the input side of a mesh router. Fixed-size packets arrive with a destination port number and go into one slot memory. The store keeps one queue per destination inside that memory. Each queue is a chain of slots joined by a next-slot table, and a head and tail pointer per destination mark its ends. A FIFO holds the indices of unused slots. Queue lengths are not fixed: any destination can use every free slot. Because each destination has its own queue, a stalled output never holds back packets bound for other outputs.

The scheduler reads the per-destination non-empty flags. It then selects one destination on the dequeue side and gets that queue's head packet in the same cycle. The grant takes effect at the next clock edge.

The slot count is `SLOTS_PER_SRC * SRC_CNT`. With `SRC_CNT = 1` the store serves one input. With a larger value the same logic becomes one common pool for several inputs, whose arrivals are presented one per cycle on the single enqueue side.

Top module: `voq_store`

## Requirements
- R1: After reset, `nonempty_o` is all zero, `full_o` is 0 and a dequeue request returns `deq_ok_o` = 0.
- R2: Packets for one destination leave in the order in which they were accepted.
- R3: While `deq_valid_i` is high and bit `deq_port_i` of `nonempty_o` is set, `deq_ok_o` is 1 and `deq_data_o` carries that destination's oldest packet in the same cycle. The packet is removed at the next rising edge.
- R4: A single destination can occupy every slot. `full_o` is 1 exactly when all `SLOT_CNT` slots are occupied.
- R5: An enqueue request while `full_o` is 1 is refused and leaves no trace: its packet is never returned and no flag changes because of it.
- R6: A dequeue request for a destination whose `nonempty_o` bit is 0 gives `deq_ok_o` = 0 and changes no queue.
- R7: An accepted enqueue and a dequeue to different destinations in the same cycle both take effect.
- R8: An accepted enqueue and a dequeue to the same destination in the same cycle both take effect, including when that queue held exactly one packet.
- R9: When the store is full, a slot freed by a dequeue is not offered to an enqueue in the same cycle. That enqueue is refused, and `full_o` drops at the following edge.
- R10: Bit p of `nonempty_o` (bit 0 = destination 0) is 1 exactly when destination p holds at least one packet. It clears after that destination's last packet is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue request |
| enq_port_i | input | PORT_W | Destination of the arriving packet |
| enq_data_i | input | DATA_W | Arriving packet |
| full_o | output | 1 | No free slot; enqueue refused |
| deq_valid_i | input | 1 | Dequeue request from the scheduler |
| deq_port_i | input | PORT_W | Destination queue to read |
| deq_ok_o | output | 1 | Request names a non-empty queue; packet is valid |
| deq_data_o | output | DATA_W | Head packet of the selected queue |
| nonempty_o | output | DEST_CNT | One flag per destination queue |

## Verification
The hardest case to reach from the ports is a full pool that frees a slot in the same cycle as a new arrival. In that cycle the free-slot FIFO is both empty and being written.

The bench reaches it by sending every slot's worth of packets to one destination. It then sets a dequeue for that destination and an enqueue for another destination in the same cycle. Afterwards the refused packet must never come out, and the next arrival must take the freed slot.

Same-cycle enqueue and dequeue on a queue of length one is reached through the vector table. The ring wrap of the free-slot FIFO is exercised by draining the full queue after earlier traffic.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int unsigned DEF_SLOTS_PER_SRC = 32;
  localparam int unsigned DEF_DATA_W        = 72;
  localparam int unsigned DEF_DEST_CNT      = 8;

  // index step with wrap for rings of any length
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned len);
    return (idx == len - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/voq_free_fifo.sv
module voq_free_fifo #(
  parameter  int unsigned SLOT_CNT = 32,
  localparam int unsigned IDX_W    = $clog2(SLOT_CNT),
  localparam int unsigned CNT_W    = $clog2(SLOT_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  output logic [IDX_W-1:0] top_idx_o,
  output logic             empty_o
);
  logic [IDX_W-1:0] slot_q [SLOT_CNT];
  logic [IDX_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o   = (cnt_q == '0);
  assign top_idx_o = slot_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOT_CNT; i++) slot_q[i] <= IDX_W'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CNT_W'(SLOT_CNT);
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= push_idx_i;
        wr_q         <= IDX_W'(voq_pkg::ring_next(int'(wr_q), SLOT_CNT));
      end
      if (pop_i) rd_q <= IDX_W'(voq_pkg::ring_next(int'(rd_q), SLOT_CNT));
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/voq_pkt_mem.sv
module voq_pkt_mem #(
  parameter  int unsigned SLOT_CNT = 32,
  parameter  int unsigned DATA_W   = 72,
  localparam int unsigned IDX_W    = $clog2(SLOT_CNT)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [SLOT_CNT];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/voq_link_ctrl.sv
module voq_link_ctrl #(
  parameter  int unsigned SLOT_CNT = 32,
  parameter  int unsigned DEST_CNT = 8,
  localparam int unsigned IDX_W    = $clog2(SLOT_CNT),
  localparam int unsigned PORT_W   = $clog2(DEST_CNT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enq_acc_i,
  input  logic [PORT_W-1:0]   enq_port_i,
  input  logic [IDX_W-1:0]    new_slot_i,
  input  logic                deq_valid_i,
  input  logic [PORT_W-1:0]   deq_port_i,
  output logic                deq_ok_o,
  output logic [IDX_W-1:0]    head_slot_o,
  output logic [DEST_CNT-1:0] nonempty_o
);
  logic [IDX_W-1:0] next_q [SLOT_CNT];
  logic [IDX_W-1:0] head_all [DEST_CNT];
  logic [IDX_W-1:0] tail_all [DEST_CNT];
  logic             deq_acc;

  assign deq_acc     = deq_valid_i & nonempty_o[deq_port_i];
  assign deq_ok_o    = deq_acc;
  assign head_slot_o = head_all[deq_port_i];

  // link the new slot behind the current tail of a non-empty queue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOT_CNT; i++) next_q[i] <= '0;
    end else if (enq_acc_i && nonempty_o[enq_port_i]) begin
      next_q[tail_all[enq_port_i]] <= new_slot_i;
    end
  end

  for (genvar d = 0; d < DEST_CNT; d++) begin : g_dest
    logic [IDX_W-1:0] hd_q, tl_q;
    logic             vl_q;
    logic             enq_hit, deq_hit;

    assign enq_hit = enq_acc_i && (enq_port_i == PORT_W'(d));
    assign deq_hit = deq_acc && (deq_port_i == PORT_W'(d));
    assign head_all[d]   = hd_q;
    assign tail_all[d]   = tl_q;
    assign nonempty_o[d] = vl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hd_q <= '0;
        tl_q <= '0;
        vl_q <= 1'b0;
      end else if (deq_hit) begin
        if (hd_q == tl_q) begin
          // last packet leaves; a same-cycle arrival becomes the whole queue
          if (enq_hit) begin
            hd_q <= new_slot_i;
            tl_q <= new_slot_i;
          end else begin
            vl_q <= 1'b0;
          end
        end else begin
          hd_q <= next_q[hd_q];
          if (enq_hit) tl_q <= new_slot_i;
        end
      end else if (enq_hit) begin
        tl_q <= new_slot_i;
        if (!vl_q) begin
          hd_q <= new_slot_i;
          vl_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/voq_store.sv
module voq_store #(
  parameter  int unsigned SLOTS_PER_SRC = voq_pkg::DEF_SLOTS_PER_SRC,
  parameter  int unsigned SRC_CNT       = 1,
  parameter  int unsigned DATA_W        = voq_pkg::DEF_DATA_W,
  parameter  int unsigned DEST_CNT      = voq_pkg::DEF_DEST_CNT,
  localparam int unsigned SLOT_CNT      = SLOTS_PER_SRC * SRC_CNT,
  localparam int unsigned IDX_W         = $clog2(SLOT_CNT),
  localparam int unsigned PORT_W        = $clog2(DEST_CNT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enq_valid_i,
  input  logic [PORT_W-1:0]   enq_port_i,
  input  logic [DATA_W-1:0]   enq_data_i,
  output logic                full_o,
  input  logic                deq_valid_i,
  input  logic [PORT_W-1:0]   deq_port_i,
  output logic                deq_ok_o,
  output logic [DATA_W-1:0]   deq_data_o,
  output logic [DEST_CNT-1:0] nonempty_o
);
  logic             free_empty, enq_acc;
  logic [IDX_W-1:0] new_slot, head_slot;

  // full is judged before this cycle's release, so a freed slot waits a cycle
  assign full_o  = free_empty;
  assign enq_acc = enq_valid_i & ~free_empty;

  voq_free_fifo #(.SLOT_CNT(SLOT_CNT)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (enq_acc),
    .push_i     (deq_ok_o),
    .push_idx_i (head_slot),
    .top_idx_o  (new_slot),
    .empty_o    (free_empty)
  );

  voq_link_ctrl #(.SLOT_CNT(SLOT_CNT), .DEST_CNT(DEST_CNT)) u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_acc_i   (enq_acc),
    .enq_port_i  (enq_port_i),
    .new_slot_i  (new_slot),
    .deq_valid_i (deq_valid_i),
    .deq_port_i  (deq_port_i),
    .deq_ok_o    (deq_ok_o),
    .head_slot_o (head_slot),
    .nonempty_o  (nonempty_o)
  );

  voq_pkt_mem #(.SLOT_CNT(SLOT_CNT), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (enq_acc),
    .waddr_i (new_slot),
    .wdata_i (enq_data_i),
    .raddr_i (head_slot),
    .rdata_o (deq_data_o)
  );
endmodule

// File: rtl/voq_store_chk.sv
module voq_store_chk #(
  parameter  int unsigned SLOT_CNT = 32,
  parameter  int unsigned DEST_CNT = 8,
  localparam int unsigned PORT_W   = $clog2(DEST_CNT),
  localparam int unsigned OCC_W    = $clog2(SLOT_CNT + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enq_valid_i,
  input logic [PORT_W-1:0]   enq_port_i,
  input logic                full_o,
  input logic                deq_valid_i,
  input logic [PORT_W-1:0]   deq_port_i,
  input logic                deq_ok_o,
  input logic [DEST_CNT-1:0] nonempty_o
);
  logic [OCC_W-1:0] occ_q;
  logic             enq_take;

  assign enq_take = enq_valid_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else if (enq_take && !deq_ok_o) occ_q <= occ_q + OCC_W'(1);
    else if (deq_ok_o && !enq_take) occ_q <= occ_q - OCC_W'(1);
  end

  assert_full_at_capacity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (occ_q == OCC_W'(SLOT_CNT)));

  assert_flags_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) == (nonempty_o == '0));

  assert_full_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !deq_ok_o |=> full_o);

  assert_freed_slot_later_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && deq_ok_o |=> !full_o);

  assert_enq_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_take |=> nonempty_o[$past(enq_port_i)]);

  assert_empty_deq_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_i && !nonempty_o[deq_port_i] |-> !deq_ok_o);
endmodule

bind voq_store voq_store_chk #(.SLOT_CNT(SLOT_CNT), .DEST_CNT(DEST_CNT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enq_valid_i (enq_valid_i),
  .enq_port_i  (enq_port_i),
  .full_o      (full_o),
  .deq_valid_i (deq_valid_i),
  .deq_port_i  (deq_port_i),
  .deq_ok_o    (deq_ok_o),
  .nonempty_o  (nonempty_o)
);

// File: tb/sim_voq_store.sv
module sim_voq_store;
  localparam int unsigned SLOTS = 32;
  localparam int unsigned DW    = 72;
  localparam int unsigned NDST  = 8;
  localparam int unsigned NVEC  = 11;

  // {enq_v, enq_p[2:0], enq_tag[7:0], deq_v, deq_p[2:0], exp_ok, exp_tag[7:0], exp_nonempty[7:0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 8'd1, 1'b1, 3'd5, 1'b0, 8'd0, 8'h04},  // R6 empty deq
    {1'b1, 3'd2, 8'd2, 1'b0, 3'd0, 1'b0, 8'd0, 8'h04},
    {1'b1, 3'd5, 8'd3, 1'b1, 3'd2, 1'b1, 8'd1, 8'h24},  // R7
    {1'b1, 3'd2, 8'd4, 1'b1, 3'd5, 1'b1, 8'd3, 8'h04},  // R7
    {1'b1, 3'd0, 8'd5, 1'b1, 3'd2, 1'b1, 8'd2, 8'h05},  // R2
    {1'b1, 3'd0, 8'd6, 1'b1, 3'd0, 1'b1, 8'd5, 8'h05},  // R8 single + enq
    {1'b0, 3'd0, 8'd0, 1'b1, 3'd0, 1'b1, 8'd6, 8'h04},  // R8
    {1'b1, 3'd7, 8'd7, 1'b1, 3'd2, 1'b1, 8'd4, 8'h80},  // R2
    {1'b1, 3'd7, 8'd8, 1'b1, 3'd7, 1'b1, 8'd7, 8'h80},  // R8
    {1'b0, 3'd0, 8'd0, 1'b1, 3'd7, 1'b1, 8'd8, 8'h00},  // R10
    {1'b0, 3'd0, 8'd0, 1'b1, 3'd3, 1'b0, 8'd0, 8'h00}   // R6
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            enq_valid_i = 1'b0;
  logic [2:0]      enq_port_i = '0;
  logic [DW-1:0]   enq_data_i = '0;
  logic            full_o;
  logic            deq_valid_i = 1'b0;
  logic [2:0]      deq_port_i = '0;
  logic            deq_ok_o;
  logic [DW-1:0]   deq_data_o;
  logic [NDST-1:0] nonempty_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  voq_store u0 (
    .clk_i, .rst_ni, .enq_valid_i, .enq_port_i, .enq_data_i, .full_o,
    .deq_valid_i, .deq_port_i, .deq_ok_o, .deq_data_o, .nonempty_o
  );

  function automatic logic [DW-1:0] mk(input logic [7:0] t);
    return {t, 8'h5A, {7{t ^ 8'h3C}}};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ev, input logic [2:0] ep, input logic [7:0] et,
                       input logic dv, input logic [2:0] dp);
    enq_valid_i = ev;
    enq_port_i  = ep;
    enq_data_i  = mk(et);
    deq_valid_i = dv;
    deq_port_i  = dp;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 nonempty", DW'(nonempty_o), DW'(0));
    check("R1 full", DW'(full_o), DW'(0));
    drive(1'b0, 3'd0, 8'd0, 1'b1, 3'd0);
    #1 check("R1 deq_ok", DW'(deq_ok_o), DW'(0));
    @(negedge clk_i);
    check("R1 nonempty after deq", DW'(nonempty_o), DW'(0));

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][32], VEC[i][31:29], VEC[i][28:21], VEC[i][20], VEC[i][19:17]);
      #1;
      if (VEC[i][20]) begin
        check($sformatf("R3/R6 deq_ok vec%0d", i), DW'(deq_ok_o), DW'(VEC[i][16]));
        if (VEC[i][16]) check($sformatf("R2/R3 data vec%0d", i), deq_data_o, mk(VEC[i][15:8]));
      end
      @(negedge clk_i);
      check($sformatf("R10 nonempty vec%0d", i), DW'(nonempty_o), DW'(VEC[i][7:0]));
      check($sformatf("R4 not full vec%0d", i), DW'(full_o), DW'(0));
    end
    drive(1'b0, 3'd0, 8'd0, 1'b0, 3'd0);
    @(negedge clk_i);

    // fill one destination with every slot
    for (int i = 0; i < SLOTS; i++) begin
      drive(1'b1, 3'd3, 8'(100 + i), 1'b0, 3'd0);
      #1 if (i == SLOTS - 1) check("R4 not full before last slot", DW'(full_o), DW'(0));
      @(negedge clk_i);
    end
    drive(1'b0, 3'd0, 8'd0, 1'b0, 3'd0);
    check("R4 full after all slots", DW'(full_o), DW'(1));
    check("R4 one queue holds all", DW'(nonempty_o), DW'(8'h08));

    // refused enqueue
    drive(1'b1, 3'd1, 8'hEE, 1'b0, 3'd0);
    @(negedge clk_i);
    check("R5 flags untouched", DW'(nonempty_o), DW'(8'h08));
    check("R5 still full", DW'(full_o), DW'(1));

    // free and arrive in the same full cycle
    drive(1'b1, 3'd1, 8'hEF, 1'b1, 3'd3);
    #1;
    check("R9 full during release", DW'(full_o), DW'(1));
    check("R9 deq_ok", DW'(deq_ok_o), DW'(1));
    check("R2 first out", deq_data_o, mk(8'd100));
    @(negedge clk_i);
    drive(1'b0, 3'd0, 8'd0, 1'b0, 3'd0);
    check("R9 full drops next", DW'(full_o), DW'(0));
    check("R9 arrival refused", DW'(nonempty_o), DW'(8'h08));

    drive(1'b1, 3'd1, 8'hF0, 1'b0, 3'd0);
    @(negedge clk_i);
    drive(1'b0, 3'd0, 8'd0, 1'b0, 3'd0);
    check("R9 freed slot reused", DW'(full_o), DW'(1));
    check("R10 two queues", DW'(nonempty_o), DW'(8'h0A));

    // drain in order
    for (int i = 1; i < SLOTS; i++) begin
      drive(1'b0, 3'd0, 8'd0, 1'b1, 3'd3);
      #1 check($sformatf("R2 order %0d", i), deq_data_o, mk(8'(100 + i)));
      @(negedge clk_i);
    end
    drive(1'b0, 3'd0, 8'd0, 1'b1, 3'd1);
    check("R10 drained queue clear", DW'(nonempty_o), DW'(8'h02));
    #1 check("R5 refused packets absent", deq_data_o, mk(8'hF0));
    @(negedge clk_i);
    drive(1'b0, 3'd0, 8'd0, 1'b0, 3'd0);
    check("R10 all clear", DW'(nonempty_o), DW'(0));
    check("R4 not full when empty", DW'(full_o), DW'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule